// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block controls a bank of general-purpose lines through a small word-wide register interface with separate read and write strobes. Each line is set up on its own as a driven output, a plain input, or an interrupt source. Interrupt sources sense a level or an edge. The edge can be one edge or both edges, and the polarity is selectable.

Every pin input passes through a two-flop synchroniser and then a per-line sampling gate before any use. Edge events are latched in per-line pending bits. Software clears those bits by writing ones. Level events show the live, polarity-adjusted input state instead. A per-line enable mask has two write ports: one port only sets bits and the other only clears them. One registered interrupt output reports any pending line that is enabled.

A processor-side driver uses the bank as follows. It programs the mode registers, enables the lines it cares about, and on an interrupt reads the pending word. It acknowledges edge events through the clear port.

Top module: `gpio_irq_bank`

Register map (byte offsets; bit i of each register belongs to line i):

| Offset | Name | Access | Meaning |
|---|---|---|---|
| 0x00 | lineIrqSel | RW | 1 = interrupt source, 0 = general I/O |
| 0x04 | lineDir | RW | in general I/O mode: 1 = output, 0 = input |
| 0x08 | outVal | RW | value driven on output lines |
| 0x0C | inVal | RO | synchronised, gated pin state |
| 0x10 | pendStat | RO | per-line pending state |
| 0x14 | pendClr | WO | a 1 clears that line's latched edge event |
| 0x18 | irqEn | RW | reads the enable mask; a written 0 clears a bit, a written 1 keeps it |
| 0x1C | irqEnSet | WO | a 1 sets that line's enable bit |
| 0x20 | polSel | RW | 1 = active-low level or falling edge |
| 0x24 | edgeSel | RW | 1 = edge sensing, 0 = level sensing |
| 0x28 | filtCfg | RW | storage only |
| 0x40 | outSrcCfg | RW | storage only |
| 0x4C | dualEdge | RW | with edgeSel = 1: 1 = both edges |
| 0x50 | inGate | RW | 1 = the line's input is sampled |

## Requirements
- R1: After reset, every register reads 0, irqOut is 0 and pinOe is 0.
- R2: A line with lineIrqSel bit 0 and lineDir bit 1 drives pinOe high and pinOut from its outVal bit. A line in interrupt mode never drives pinOe.
- R3: inVal (0x0C) shows a pin change at the third rising clock edge after the change when the line's inGate (0x50) bit is 1. It reads 0 for lines whose inGate bit is 0.
- R4: For an interrupt line with edgeSel 0, the pendStat (0x10) bit equals the sampled input XOR its polSel bit. Writing 1 to pendClr has no lasting effect on it.
- R5: For an interrupt line with edgeSel 1 and dualEdge 0, a rising sampled input (polSel 0) or a falling one (polSel 1) latches the pending bit. The opposite edge does not latch it.
- R6: For an interrupt line with edgeSel 1 and dualEdge 1, both rising and falling edges latch the pending bit.
- R7: Writing pendClr (0x14) clears the latched bits where the written data has 1s and leaves bits where it has 0s. An edge in the same cycle wins over the clear.
- R8: Writing 1s to irqEnSet (0x1C) sets enable bits. Writing irqEn (0x18) clears the bits written as 0 and keeps those written as 1. Reading 0x18 returns the mask.
- R9: irqOut is the OR over all lines of pendStat AND irqEn, registered once. It rises one clock edge after a line's pending state and enable are both 1.
- R10: A line whose lineIrqSel bit is 0 never shows a pending bit, whatever its pin does.
- R11: filtCfg (0x28) and outSrcCfg (0x40) read back the value written. Writes to the read-only offsets 0x0C and 0x10 change nothing.
- R12: Read data is registered: rdData holds the addressed value from the clock edge on which rdEn is high. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W (7) | Byte offset of the register |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Registered read data |
| pinIn | input | NLINES (32) | Asynchronous pin inputs |
| pinOut | output | NLINES (32) | Output values |
| pinOe | output | NLINES (32) | Per-line output enable |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A pin change counts three clock edges to reach inVal: two synchroniser flops and the gate register. A level pending state follows that at once. A latched edge event needs a fourth edge, and irqOut registers one edge after its source. A register write takes effect on the edge that samples the strobe, and read data is valid on the same edge. The bench drives and samples on falling edges and counts the exact number of falling edges to each of these points. It checks irqOut both one cycle early, where it must still be 0, and at the due cycle. It also reads inVal one edge too early to confirm the old value is still there.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam logic [6:0] OFF_IRQ_SEL  = 7'h00;
  localparam logic [6:0] OFF_DIR      = 7'h04;
  localparam logic [6:0] OFF_OUT      = 7'h08;
  localparam logic [6:0] OFF_IN       = 7'h0C;
  localparam logic [6:0] OFF_PEND     = 7'h10;
  localparam logic [6:0] OFF_PEND_CLR = 7'h14;
  localparam logic [6:0] OFF_EN       = 7'h18;
  localparam logic [6:0] OFF_EN_SET   = 7'h1C;
  localparam logic [6:0] OFF_POL      = 7'h20;
  localparam logic [6:0] OFF_EDGE     = 7'h24;
  localparam logic [6:0] OFF_FILT     = 7'h28;
  localparam logic [6:0] OFF_OUT_SRC  = 7'h40;
  localparam logic [6:0] OFF_DUAL     = 7'h4C;
  localparam logic [6:0] OFF_GATE     = 7'h50;

  typedef struct packed {
    logic wrIrqSel;
    logic wrDir;
    logic wrOut;
    logic wrPendClr;
    logic wrEnClr;
    logic wrEnSet;
    logic wrPol;
    logic wrEdge;
    logic wrFilt;
    logic wrOutSrc;
    logic wrDual;
    logic wrGate;
    logic rdStb;
  } bankStrobe_t;

  typedef enum logic [3:0] {
    RD_NONE, RD_IRQ_SEL, RD_DIR, RD_OUT, RD_IN, RD_PEND, RD_EN,
    RD_POL, RD_EDGE, RD_FILT, RD_OUT_SRC, RD_DUAL, RD_GATE
  } rdSel_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output bankStrobe_t       strb,
  output rdSel_t            rdSel
);

  always_comb begin
    strb  = '0;
    rdSel = RD_NONE;
    strb.rdStb = rdEn;
    if (wrEn) begin
      case (addr)
        ADDR_W'(OFF_IRQ_SEL):  strb.wrIrqSel  = 1'b1;
        ADDR_W'(OFF_DIR):      strb.wrDir     = 1'b1;
        ADDR_W'(OFF_OUT):      strb.wrOut     = 1'b1;
        ADDR_W'(OFF_PEND_CLR): strb.wrPendClr = 1'b1;
        ADDR_W'(OFF_EN):       strb.wrEnClr   = 1'b1;
        ADDR_W'(OFF_EN_SET):   strb.wrEnSet   = 1'b1;
        ADDR_W'(OFF_POL):      strb.wrPol     = 1'b1;
        ADDR_W'(OFF_EDGE):     strb.wrEdge    = 1'b1;
        ADDR_W'(OFF_FILT):     strb.wrFilt    = 1'b1;
        ADDR_W'(OFF_OUT_SRC):  strb.wrOutSrc  = 1'b1;
        ADDR_W'(OFF_DUAL):     strb.wrDual    = 1'b1;
        ADDR_W'(OFF_GATE):     strb.wrGate    = 1'b1;
        default: ;
      endcase
    end
    if (rdEn) begin
      case (addr)
        ADDR_W'(OFF_IRQ_SEL): rdSel = RD_IRQ_SEL;
        ADDR_W'(OFF_DIR):     rdSel = RD_DIR;
        ADDR_W'(OFF_OUT):     rdSel = RD_OUT;
        ADDR_W'(OFF_IN):      rdSel = RD_IN;
        ADDR_W'(OFF_PEND):    rdSel = RD_PEND;
        ADDR_W'(OFF_EN):      rdSel = RD_EN;
        ADDR_W'(OFF_POL):     rdSel = RD_POL;
        ADDR_W'(OFF_EDGE):    rdSel = RD_EDGE;
        ADDR_W'(OFF_FILT):    rdSel = RD_FILT;
        ADDR_W'(OFF_OUT_SRC): rdSel = RD_OUT_SRC;
        ADDR_W'(OFF_DUAL):    rdSel = RD_DUAL;
        ADDR_W'(OFF_GATE):    rdSel = RD_GATE;
        default:              rdSel = RD_NONE;
      endcase
    end
  end

  logic [11:0] wrVec;
  assign wrVec = {strb.wrIrqSel, strb.wrDir, strb.wrOut, strb.wrPendClr,
                  strb.wrEnClr, strb.wrEnSet, strb.wrPol, strb.wrEdge,
                  strb.wrFilt, strb.wrOutSrc, strb.wrDual, strb.wrGate};

  // R11
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrVec));

  // R11
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (wrVec == '0));

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strb,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NLINES-1:0] pinIn,
  output logic [NLINES-1:0] pinOut,
  output logic [NLINES-1:0] pinOe,
  output logic              irqOut
);

  localparam int LW = NLINES;

  logic [LW-1:0] wrD;
  assign wrD = wrData[LW-1:0];

  logic [LW-1:0] irqSel, dirSel, outVal, polSel, edgeSel, dualSel, inGate;
  logic [LW-1:0] enMask;
  logic [DATA_W-1:0] filtCfg, outSrcCfg;
  logic [LW-1:0] syncA, syncB, inVal, inPrev, pendLatch;
  logic [LW-1:0] hit, pend;
  logic          irqOutR;

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqSel    <= '0;
      dirSel    <= '0;
      outVal    <= '0;
      polSel    <= '0;
      edgeSel   <= '0;
      dualSel   <= '0;
      inGate    <= '0;
      filtCfg   <= '0;
      outSrcCfg <= '0;
    end else begin
      if (strb.wrIrqSel) irqSel    <= wrD;
      if (strb.wrDir)    dirSel    <= wrD;
      if (strb.wrOut)    outVal    <= wrD;
      if (strb.wrPol)    polSel    <= wrD;
      if (strb.wrEdge)   edgeSel   <= wrD;
      if (strb.wrDual)   dualSel   <= wrD;
      if (strb.wrGate)   inGate    <= wrD;
      if (strb.wrFilt)   filtCfg   <= wrData;
      if (strb.wrOutSrc) outSrcCfg <= wrData;
    end
  end

  // enable mask: separate set and clear ports
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask <= '0;
    end else if (strb.wrEnSet) begin
      enMask <= enMask | wrD;
    end else if (strb.wrEnClr) begin
      enMask <= enMask & wrD;
    end
  end

  // input synchroniser and sampling gate
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      inVal  <= '0;
      inPrev <= '0;
    end else begin
      syncA  <= pinIn;
      syncB  <= syncA;
      inVal  <= syncB & inGate;
      inPrev <= inVal;
    end
  end

  // per-line sensing
  for (genvar i = 0; i < LW; i++) begin : g_line
    logic rise, fall, lvlAct;
    assign rise   = inVal[i] & ~inPrev[i];
    assign fall   = ~inVal[i] & inPrev[i];
    assign lvlAct = inVal[i] ^ polSel[i];
    assign hit[i] = irqSel[i] & edgeSel[i] &
                    (dualSel[i] ? (rise | fall) : (polSel[i] ? fall : rise));
    assign pend[i] = irqSel[i] & (edgeSel[i] ? pendLatch[i] : lvlAct);
  end

  logic [LW-1:0] clrMask;
  assign clrMask = strb.wrPendClr ? wrD : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendLatch <= '0;
      irqOutR   <= 1'b0;
    end else begin
      pendLatch <= hit | (pendLatch & ~clrMask);
      irqOutR   <= |(pend & enMask);
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdStb) begin
      case (rdSel)
        RD_IRQ_SEL: rdData <= DATA_W'(irqSel);
        RD_DIR:     rdData <= DATA_W'(dirSel);
        RD_OUT:     rdData <= DATA_W'(outVal);
        RD_IN:      rdData <= DATA_W'(inVal);
        RD_PEND:    rdData <= DATA_W'(pend);
        RD_EN:      rdData <= DATA_W'(enMask);
        RD_POL:     rdData <= DATA_W'(polSel);
        RD_EDGE:    rdData <= DATA_W'(edgeSel);
        RD_FILT:    rdData <= filtCfg;
        RD_OUT_SRC: rdData <= outSrcCfg;
        RD_DUAL:    rdData <= DATA_W'(dualSel);
        RD_GATE:    rdData <= DATA_W'(inGate);
        default:    rdData <= '0;
      endcase
    end
  end

  assign pinOut = outVal;
  assign pinOe  = dirSel & ~irqSel;
  assign irqOut = irqOutR;

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPendClr |=> ((pendLatch & $past(wrD & ~hit)) == '0));

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPendClr |=> ((pendLatch & $past(pendLatch)) == $past(pendLatch)));

  // R8
  en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEnSet |=> ((enMask & $past(wrD)) == $past(wrD)));

  // R8
  en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEnClr |=> ((enMask & ~$past(wrD)) == '0));

  // R3
  in_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((inVal & ~$past(inGate)) == '0));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enMask) == '0) |-> !irqOut);

  // R2
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrIrqSel |=> $stable(irqSel));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NLINES-1:0] pinIn,
  output logic [NLINES-1:0] pinOut,
  output logic [NLINES-1:0] pinOe,
  output logic              irqOut
);

  bankStrobe_t strb;
  rdSel_t      rdSel;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .strb  (strb),
    .rdSel (rdSel)
  );

  gpio_bank_datapath #(.NLINES(NLINES), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdSel  (rdSel),
    .wrData (wrData),
    .rdData (rdData),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqOut (irqOut)
  );

endmodule

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_bank dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start just after a falling edge and end just after one
  task automatic doWrite(input logic [6:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [6:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irqOut", {31'd0, irqOut}, 32'd0);
    chk("R1 pinOe", pinOe, 32'd0);
    doRead(7'h00, v); chk("R1 lineIrqSel", v, 32'd0);
    doRead(7'h18, v); chk("R1 irqEn", v, 32'd0);
    doRead(7'h10, v); chk("R1 pendStat", v, 32'd0);
    doRead(7'h50, v); chk("R1 inGate", v, 32'd0);
  endtask

  task automatic t_output();
    doWrite(7'h04, 32'h0000_00F0);
    doWrite(7'h08, 32'h0000_00A5);
    chk("R2 pinOe", pinOe, 32'h0000_00F0);
    chk("R2 pinOut", pinOut, 32'h0000_00A5);
    doWrite(7'h00, 32'h0000_0010);
    chk("R2 irq line no drive", pinOe, 32'h0000_00E0);
    doWrite(7'h00, 32'h0);
    doWrite(7'h04, 32'h0);
    chk("R2 inputs no drive", pinOe, 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    pinIn = 32'hFFFF_0000;
    waitN(5);
    doRead(7'h0C, v); chk("R3 gated off", v, 32'h0);
    doWrite(7'h50, 32'hFFFF_FFFF);
    waitN(4);
    doRead(7'h0C, v); chk("R3 gated on", v, 32'hFFFF_0000);
    pinIn = 32'h1234_5678;
    waitN(2);
    doRead(7'h0C, v); chk("R3 not before third edge", v, 32'hFFFF_0000);
    doRead(7'h0C, v); chk("R3 at third edge", v, 32'h1234_5678);
    pinIn = 32'h0;
    waitN(5);
  endtask

  task automatic t_storage();
    logic [31:0] v;
    doWrite(7'h28, 32'hDEAD_BEEF);
    doRead(7'h28, v); chk("R11 filtCfg", v, 32'hDEAD_BEEF);
    doWrite(7'h40, 32'h0BAD_F00D);
    doRead(7'h40, v); chk("R11 outSrcCfg", v, 32'h0BAD_F00D);
    doWrite(7'h0C, 32'hFFFF_FFFF);
    doRead(7'h0C, v); chk("R11 inVal read-only", v, 32'h0);
    doWrite(7'h10, 32'hFFFF_FFFF);
    doRead(7'h10, v); chk("R11 pendStat read-only", v, 32'h0);
    doRead(7'h30, v); chk("R12 unmapped reads 0", v, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    doWrite(7'h00, 32'h0000_0001);
    doWrite(7'h1C, 32'h0000_0001);
    doRead(7'h10, v); chk("R4 idle level", v, 32'h0);
    pinIn = 32'h0000_0001;
    waitN(3);
    chk("R9 level irq not early", {31'd0, irqOut}, 32'd0);
    waitN(1);
    chk("R9 level irq due", {31'd0, irqOut}, 32'd1);
    doRead(7'h10, v); chk("R4 level pending", v, 32'h1);
    doWrite(7'h14, 32'h0000_0001);
    doRead(7'h10, v); chk("R4 clear no effect on level", v, 32'h1);
    pinIn = 32'h0;
    waitN(5);
    doRead(7'h10, v); chk("R4 level released", v, 32'h0);
    chk("R9 irq released", {31'd0, irqOut}, 32'd0);
    doWrite(7'h20, 32'h0000_0001);
    doRead(7'h10, v); chk("R4 active-low level", v, 32'h1);
    doWrite(7'h00, 32'h0);
    doWrite(7'h20, 32'h0);
    pinIn = 32'h0000_0002;
    waitN(5);
    doRead(7'h10, v); chk("R10 io line never pends", v, 32'h0);
    pinIn = 32'h0;
    waitN(5);
    doRead(7'h10, v); chk("R10 io line after toggle", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    doWrite(7'h24, 32'h0000_000C);
    doWrite(7'h00, 32'h0000_0004);
    doWrite(7'h14, 32'hFFFF_FFFF);
    doWrite(7'h1C, 32'h0000_0004);
    pinIn = 32'h0000_0004;
    waitN(4);
    chk("R9 edge irq not early", {31'd0, irqOut}, 32'd0);
    waitN(1);
    chk("R9 edge irq due", {31'd0, irqOut}, 32'd1);
    doRead(7'h10, v); chk("R5 rising latched", v, 32'h4);
    pinIn = 32'h0;
    waitN(5);
    doRead(7'h10, v); chk("R5 latch holds after release", v, 32'h4);
    doWrite(7'h14, 32'hFFFF_FFFB);
    doRead(7'h10, v); chk("R7 zero bits keep pending", v, 32'h4);
    doWrite(7'h14, 32'h0000_0004);
    doRead(7'h10, v); chk("R7 one bit clears", v, 32'h0);
    waitN(1);
    chk("R9 irq drops after clear", {31'd0, irqOut}, 32'd0);
    doWrite(7'h20, 32'h0000_0004);
    pinIn = 32'h0000_0004;
    waitN(5);
    doRead(7'h10, v); chk("R5 rising ignored when falling chosen", v, 32'h0);
    pinIn = 32'h0;
    waitN(5);
    doRead(7'h10, v); chk("R5 falling latched", v, 32'h4);
  endtask

  task automatic t_dual();
    logic [31:0] v;
    doWrite(7'h4C, 32'h0000_0008);
    doWrite(7'h00, 32'h0000_000C);
    doWrite(7'h14, 32'h0000_0008);
    pinIn = 32'h0000_0008;
    waitN(5);
    doRead(7'h10, v); chk("R6 dual rising", v & 32'h8, 32'h8);
    doWrite(7'h14, 32'h0000_0008);
    doRead(7'h10, v); chk("R6 dual cleared", v & 32'h8, 32'h0);
    pinIn = 32'h0;
    waitN(5);
    doRead(7'h10, v); chk("R6 dual falling", v & 32'h8, 32'h8);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    doWrite(7'h18, 32'h0);
    doRead(7'h18, v); chk("R8 clear all", v, 32'h0);
    waitN(1);
    chk("R9 masked pending quiet", {31'd0, irqOut}, 32'd0);
    doWrite(7'h1C, 32'h0000_0F0F);
    doRead(7'h18, v); chk("R8 set port", v, 32'h0000_0F0F);
    doWrite(7'h18, 32'hFFFF_00FF);
    doRead(7'h18, v); chk("R8 clear port keeps ones", v, 32'h0000_000F);
    doWrite(7'h1C, 32'h0);
    doRead(7'h18, v); chk("R8 set port zeros no effect", v, 32'h0000_000F);
    doWrite(7'h18, 32'h0);
    doWrite(7'h1C, 32'h0000_0008);
    chk("R9 not before register", {31'd0, irqOut}, 32'd0);
    waitN(1);
    chk("R9 enable raises irq", {31'd0, irqOut}, 32'd1);
    doWrite(7'h18, 32'hFFFF_FFF7);
    waitN(1);
    chk("R9 disable drops irq", {31'd0, irqOut}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_output();
    t_input();
    t_storage();
    t_level();
    t_edge();
    t_dual();
    t_mask();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule